// File: doc/BRIEF.md
# Scoreboard Issue Gate for an In-Order Pipeline

This block sits between decode and execute in a single-issue, in-order pipeline. Every architectural register keeps a busy/free mark next to its value. One decoded instruction at a time is held in a single-slot window; it carries an opcode, a function-unit number, a destination register and two source registers. Each cycle the block decides whether that held instruction may leave. It leaves only when the marks of its destination and of both sources show "free" and the requested function unit reports that it is idle. When it leaves, the block marks the destination busy. A later writeback stores the result and marks the register free again.

Decoded instructions enter through a valid/ready stream. The producer holds `in_valid` and the instruction fields steady until it sees `in_ready` high at a clock edge. `in_ready` is high when the window is empty, or when the held instruction leaves in this same cycle. While the held instruction waits, `in_ready` stays low, so nothing behind it can pass. The issue side has no ready input. Back-pressure from execute comes only through the per-unit `fu_free` pins. `iss_valid` is high for exactly the cycle in which the instruction leaves, and the operand values read from the register file come out in that same cycle. Writeback is a plain strobe with no back-pressure. Register 0 reads as zero, ignores writes and is never busy, so an instruction that lacks a second source names register 0 there.

Top module: `sb_issue_ctrl`

## Requirements
- R1: After reset every register is free, `in_ready` is 1 and `iss_valid` is 0.
- R2: An instruction is accepted at a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` equals "window empty OR `iss_valid`", so a new instruction can be accepted in the same cycle as the held one leaves.
- R3: `iss_valid` is 1 only when the held instruction's source 1, source 2 and destination registers are all free. A busy source is a read-after-write stall. A busy destination is a write-after-write stall.
- R4: `iss_valid` also requires `fu_free[fu]` to be 1, where `fu` is the held instruction's unit number. Another unit being busy has no effect.
- R5: When an instruction with a nonzero destination leaves, that destination is marked busy from the next cycle on. It stays busy until a writeback to it.
- R6: A writeback (`wb_valid`=1) to a nonzero register stores `wb_data` and marks that register free from the next cycle. There is no same-cycle bypass: an instruction waiting on that register leaves one cycle later, with the written value as its operand.
- R7: Write-after-read order is not checked. An instruction whose destination is a source of the instruction that just left can leave in the next cycle.
- R8: Register 0 is always free and reads as 0; writes to it are discarded. An instruction with destination 0 reserves nothing.
- R9: If a writeback and a leaving instruction name the same register in the same cycle, the register ends up busy. The data of that writeback is still stored.
- R10: While `iss_valid` is 1, `iss_opcode`, `iss_fu` and `iss_dst` equal the held instruction's fields. `iss_opa` and `iss_opb` equal the current values of source 1 and source 2.
- R11: A waiting instruction keeps its fields unchanged and leaves before any instruction offered after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_ready | output | 1 | Window can take the offered instruction this cycle |
| in_opcode | input | OPC_W | Opcode of offered instruction |
| in_fu | input | clog2(NUM_FU) | Function unit the instruction needs |
| in_dst | input | clog2(NUM_REGS) | Destination register number |
| in_src1 | input | clog2(NUM_REGS) | First source register number |
| in_src2 | input | clog2(NUM_REGS) | Second source register number (0 if unused) |
| fu_free | input | NUM_FU | One bit per unit, 1 when the unit can take work |
| wb_valid | input | 1 | Writeback strobe |
| wb_reg | input | clog2(NUM_REGS) | Register being written back |
| wb_data | input | DATA_W | Result value |
| iss_valid | output | 1 | Held instruction leaves this cycle |
| iss_opcode | output | OPC_W | Opcode of the leaving instruction |
| iss_fu | output | clog2(NUM_FU) | Unit of the leaving instruction |
| iss_dst | output | clog2(NUM_REGS) | Destination of the leaving instruction |
| iss_opa | output | DATA_W | Value of source 1 |
| iss_opb | output | DATA_W | Value of source 2 |

## Verification
The embedded properties check on every cycle that:
- a leaving destination is busy one cycle later, and a colliding writeback never frees it;
- a plain writeback frees its register and stores its data;
- a waiting instruction keeps its fields;
- nothing leaves with its unit busy;
- an instruction that uses only register 0 and has its unit free always leaves.

Other behaviours can only be shown by the bench's directed scenarios:
- the absence of a same-cycle bypass;
- accepting a new instruction in the cycle the held one leaves;
- operand values that track earlier writebacks;
- write-after-read freedom;
- strict ordering of a stalled instruction ahead of a later one.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned SB_NUM_REGS = 8;
  localparam int unsigned SB_DATA_W   = 16;
  localparam int unsigned SB_NUM_FU   = 2;
  localparam int unsigned SB_OPC_W    = 6;

  // index width for a set of n items, never below one bit
  function automatic int unsigned idx_w(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sb_ready_table.sv
module sb_ready_table #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_idx,
  input  logic                set_en,
  input  logic [IDX_W-1:0]    set_idx,
  output logic [NUM_REGS-1:0] free_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
    if (g == 0) begin : g_zero
      assign free_o[g] = 1'b1;
    end else begin : g_live
      logic free_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          free_q <= 1'b1;
        end else if (clr_en && clr_idx == IDX_W'(g)) begin
          free_q <= 1'b0;   // reservation beats a simultaneous release
        end else if (set_en && set_idx == IDX_W'(g)) begin
          free_q <= 1'b1;
        end
      end
      assign free_o[g] = free_q;
    end
  end

  // R5: a reserved destination is busy in the following cycle
  p_dst_reserved_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_idx != '0) |=> !free_o[$past(clr_idx)]);

  // R6: an uncontested release frees the register
  p_wb_frees_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && set_idx != '0 && !(clr_en && clr_idx == set_idx)) |=> free_o[$past(set_idx)]);

  // R9: collision leaves the register busy
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && set_en && clr_idx == set_idx && clr_idx != '0) |=> !free_o[$past(set_idx)]);
endmodule

// File: rtl/sb_regfile.sv
module sb_regfile #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned IDX_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_a_idx,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_a_data,
  output logic [DATA_W-1:0] rd_b_data
);
  logic [DATA_W-1:0] val [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign val[g] = '0;
    end else begin : g_live
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (wr_en && wr_idx == IDX_W'(g)) begin
          q <= wr_data;
        end
      end
      assign val[g] = q;
    end
  end

  always_comb begin
    rd_a_data = '0;
    rd_b_data = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rd_a_idx == IDX_W'(i)) rd_a_data = val[i];
      if (rd_b_idx == IDX_W'(i)) rd_b_data = val[i];
    end
  end

  // R6: written data lands in the addressed register
  p_wb_stores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx != '0) |=> val[$past(wr_idx)] == $past(wr_data));

  // R8: register 0 never holds anything but zero
  p_r0_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == '0) |-> rd_a_data == '0);
endmodule

// File: rtl/sb_issue_window.sv
module sb_issue_window #(
  parameter int unsigned OPC_W = 6,
  parameter int unsigned FU_W  = 1,
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPC_W-1:0] in_opcode,
  input  logic [FU_W-1:0]  in_fu,
  input  logic [IDX_W-1:0] in_dst,
  input  logic [IDX_W-1:0] in_src1,
  input  logic [IDX_W-1:0] in_src2,
  input  logic             take_i,
  output logic             win_valid,
  output logic [OPC_W-1:0] win_opcode,
  output logic [FU_W-1:0]  win_fu,
  output logic [IDX_W-1:0] win_dst,
  output logic [IDX_W-1:0] win_src1,
  output logic [IDX_W-1:0] win_src2
);
  logic load;

  assign in_ready = !win_valid || take_i;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid <= 1'b0;
    end else if (load) begin
      win_valid <= 1'b1;
    end else if (take_i) begin
      win_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_opcode <= '0;
      win_fu     <= '0;
      win_dst    <= '0;
      win_src1   <= '0;
      win_src2   <= '0;
    end else if (load) begin
      win_opcode <= in_opcode;
      win_fu     <= in_fu;
      win_dst    <= in_dst;
      win_src1   <= in_src1;
      win_src2   <= in_src2;
    end
  end

  // R11: a waiting instruction stays put, unchanged
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && !take_i) |=> (win_valid && $stable(win_opcode) && $stable(win_dst)
                                && $stable(win_src1) && $stable(win_src2) && $stable(win_fu)));

  // R2: the gate never takes from an empty window
  p_take_needs_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> win_valid);
endmodule

// File: rtl/sb_issue_gate.sv
module sb_issue_gate #(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned NUM_FU   = 2,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned FU_W     = 1
) (
  input  logic                win_valid,
  input  logic [IDX_W-1:0]    win_dst,
  input  logic [IDX_W-1:0]    win_src1,
  input  logic [IDX_W-1:0]    win_src2,
  input  logic [FU_W-1:0]     win_fu,
  input  logic [NUM_REGS-1:0] free_i,
  input  logic [NUM_FU-1:0]   fu_free,
  output logic                fire_o
);
  localparam int unsigned NUM_OPS = 3;

  logic [IDX_W-1:0]   op_idx [NUM_OPS];
  logic [NUM_OPS-1:0] op_ok;
  logic               unit_ok;

  assign op_idx[0] = win_dst;   // output dependence
  assign op_idx[1] = win_src1;  // true dependence
  assign op_idx[2] = win_src2;  // true dependence

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_op
    always_comb begin
      op_ok[k] = 1'b0;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (op_idx[k] == IDX_W'(i)) op_ok[k] = free_i[i];
      end
    end
  end

  always_comb begin
    unit_ok = 1'b0;
    for (int u = 0; u < NUM_FU; u++) begin
      if (win_fu == FU_W'(u)) unit_ok = fu_free[u];
    end
  end

  assign fire_o = win_valid && (&op_ok) && unit_ok;
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl
  import sb_pkg::*;
#(
  parameter int unsigned NUM_REGS = SB_NUM_REGS,
  parameter int unsigned DATA_W   = SB_DATA_W,
  parameter int unsigned NUM_FU   = SB_NUM_FU,
  parameter int unsigned OPC_W    = SB_OPC_W,
  localparam int unsigned IDX_W   = idx_w(NUM_REGS),
  localparam int unsigned FU_W    = idx_w(NUM_FU)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OPC_W-1:0]  in_opcode,
  input  logic [FU_W-1:0]   in_fu,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic [IDX_W-1:0]  in_src1,
  input  logic [IDX_W-1:0]  in_src2,
  input  logic [NUM_FU-1:0] fu_free,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_reg,
  input  logic [DATA_W-1:0] wb_data,
  output logic              iss_valid,
  output logic [OPC_W-1:0]  iss_opcode,
  output logic [FU_W-1:0]   iss_fu,
  output logic [IDX_W-1:0]  iss_dst,
  output logic [DATA_W-1:0] iss_opa,
  output logic [DATA_W-1:0] iss_opb
);
  logic                win_valid;
  logic [OPC_W-1:0]    win_opcode;
  logic [FU_W-1:0]     win_fu;
  logic [IDX_W-1:0]    win_dst, win_src1, win_src2;
  logic [NUM_REGS-1:0] reg_free;
  logic                fire;

  sb_issue_window #(.OPC_W(OPC_W), .FU_W(FU_W), .IDX_W(IDX_W)) u_window (
    .clk, .rst_n, .in_valid, .in_ready, .in_opcode, .in_fu, .in_dst, .in_src1, .in_src2,
    .take_i(fire), .win_valid, .win_opcode, .win_fu, .win_dst, .win_src1, .win_src2
  );

  sb_issue_gate #(.NUM_REGS(NUM_REGS), .NUM_FU(NUM_FU), .IDX_W(IDX_W), .FU_W(FU_W)) u_gate (
    .win_valid, .win_dst, .win_src1, .win_src2, .win_fu,
    .free_i(reg_free), .fu_free, .fire_o(fire)
  );

  sb_ready_table #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_table (
    .clk, .rst_n, .clr_en(fire), .clr_idx(win_dst),
    .set_en(wb_valid), .set_idx(wb_reg), .free_o(reg_free)
  );

  sb_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk, .rst_n, .wr_en(wb_valid), .wr_idx(wb_reg), .wr_data(wb_data),
    .rd_a_idx(win_src1), .rd_b_idx(win_src2), .rd_a_data(iss_opa), .rd_b_data(iss_opb)
  );

  assign iss_valid  = fire;
  assign iss_opcode = win_opcode;
  assign iss_fu     = win_fu;
  assign iss_dst    = win_dst;

  // R4: nothing leaves toward a busy unit
  p_unit_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> fu_free[iss_fu]);

  // R3: sources and destination are all free when leaving
  p_no_hazard_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> (reg_free[win_src1] && reg_free[win_src2] && reg_free[win_dst]));

  // R8: an instruction touching only register 0 is never held back by it
  p_r0_never_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid && win_dst == '0 && win_src1 == '0 && win_src2 == '0 && fu_free[win_fu])
      |-> iss_valid);
endmodule

// File: tb/sb_issue_ctrl_tb_top.sv
`timescale 1ns/1ps
module sb_issue_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready;
  logic [5:0]  in_opcode;
  logic [0:0]  in_fu;
  logic [2:0]  in_dst, in_src1, in_src2;
  logic [1:0]  fu_free;
  logic        wb_valid;
  logic [2:0]  wb_reg;
  logic [15:0] wb_data;
  logic        iss_valid;
  logic [5:0]  iss_opcode;
  logic [0:0]  iss_fu;
  logic [2:0]  iss_dst;
  logic [15:0] iss_opa, iss_opb;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sb_issue_ctrl dut_i (
    .clk, .rst_n, .in_valid, .in_ready, .in_opcode, .in_fu, .in_dst, .in_src1, .in_src2,
    .fu_free, .wb_valid, .wb_reg, .wb_data,
    .iss_valid, .iss_opcode, .iss_fu, .iss_dst, .iss_opa, .iss_opb
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic next();
    @(posedge clk); #1;
  endtask

  task automatic wbw(input logic [2:0] r, input logic [15:0] d);
    wb_valid = 1'b1; wb_reg = r; wb_data = d;
    next();
    wb_valid = 1'b0;
  endtask

  task automatic send(input logic [5:0] op, input logic fu, input logic [2:0] d,
                      input logic [2:0] s1, input logic [2:0] s2);
    in_opcode = op; in_fu = fu; in_dst = d; in_src1 = s1; in_src2 = s2; in_valid = 1'b1;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    next();
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 in_ready after reset", in_ready, 1);
    chk("R1 iss_valid after reset", iss_valid, 0);
    next();
  endtask

  task automatic t_basic();
    wbw(1, 16'h1111);
    wbw(2, 16'h2222);
    send(6'h05, 0, 3, 1, 2);
    @(negedge clk);
    chk("R1 fresh regs free, leaves", iss_valid, 1);
    chk("R10 opcode", iss_opcode, 6'h05);
    chk("R10 dst", iss_dst, 3);
    chk("R10 opa", iss_opa, 16'h1111);
    chk("R10 opb", iss_opb, 16'h2222);
    next();
    @(negedge clk);
    chk("R2 window empty after leave", iss_valid, 0);
    chk("R2 ready when empty", in_ready, 1);
    next();
    wbw(3, 16'h3333);
  endtask

  task automatic t_raw();
    send(6'h01, 0, 4, 1, 2);
    send(6'h02, 0, 5, 4, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 RAW stall", iss_valid, 0);
      chk("R5 dst busy blocks window", in_ready, 0);
      next();
    end
    wb_valid = 1'b1; wb_reg = 4; wb_data = 16'h4444;
    @(negedge clk);
    chk("R6 no same-cycle bypass", iss_valid, 0);
    next();
    wb_valid = 1'b0;
    @(negedge clk);
    chk("R6 leaves after writeback", iss_valid, 1);
    chk("R6 operand is written value", iss_opa, 16'h4444);
    chk("R8 src2 r0 reads zero", iss_opb, 0);
    chk("R10 dst", iss_dst, 5);
    next();
    wbw(5, 16'h5555);
  endtask

  task automatic t_waw();
    send(6'h03, 1, 6, 0, 0);
    send(6'h04, 1, 6, 1, 2);
    @(negedge clk);
    chk("R3 WAW stall", iss_valid, 0);
    next();
    wbw(6, 16'h6060);
    @(negedge clk);
    chk("R3 WAW cleared", iss_valid, 1);
    chk("R10 fu", iss_fu, 1);
    next();
    wbw(6, 16'h6161);
  endtask

  task automatic t_fu();
    fu_free = 2'b10;
    send(6'h07, 0, 7, 1, 2);
    @(negedge clk);
    chk("R4 unit busy stalls", iss_valid, 0);
    next();
    @(negedge clk);
    chk("R4 still stalled", iss_valid, 0);
    fu_free = 2'b11;
    #1;
    chk("R4 unit freed", iss_valid, 1);
    next();
    wbw(7, 16'h7070);
    fu_free = 2'b10;
    send(6'h08, 1, 7, 1, 2);
    @(negedge clk);
    chk("R4 other unit busy has no effect", iss_valid, 1);
    next();
    fu_free = 2'b11;
    wbw(7, 16'h7171);
  endtask

  task automatic t_war();
    send(6'h09, 0, 5, 2, 0);
    send(6'h0A, 0, 2, 1, 0);
    @(negedge clk);
    chk("R7 WAR not checked", iss_valid, 1);
    chk("R7 dst", iss_dst, 2);
    next();
    wbw(5, 16'h5a5a);
    wbw(2, 16'h2222);
  endtask

  task automatic t_r0();
    wbw(0, 16'hBEEF);
    send(6'h0B, 0, 0, 0, 0);
    @(negedge clk);
    chk("R8 r0-only leaves", iss_valid, 1);
    chk("R8 r0 write discarded", iss_opa, 0);
    next();
    send(6'h0C, 1, 0, 0, 0);
    @(negedge clk);
    chk("R8 dst r0 reserves nothing", iss_valid, 1);
    next();
  endtask

  task automatic t_collide();
    send(6'h0D, 0, 1, 0, 0);
    wb_valid = 1'b1; wb_reg = 1; wb_data = 16'h5555;
    next();
    wb_valid = 1'b0;
    send(6'h0E, 0, 2, 1, 0);
    @(negedge clk);
    chk("R9 collision keeps reg busy", iss_valid, 0);
    next();
    wbw(1, 16'h6666);
    @(negedge clk);
    chk("R9 released later", iss_valid, 1);
    chk("R9 later value", iss_opa, 16'h6666);
    next();
    wbw(2, 16'h2222);
  endtask

  task automatic t_order();
    send(6'h0F, 0, 5, 0, 0);
    send(6'h10, 0, 4, 5, 0);
    in_opcode = 6'h11; in_fu = 0; in_dst = 6; in_src1 = 1; in_src2 = 0; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 no accept while waiting", in_ready, 0);
    chk("R11 older stalled", iss_valid, 0);
    next();
    @(negedge clk);
    chk("R11 younger blocked", in_ready, 0);
    next();
    wbw(5, 16'h0505);
    @(negedge clk);
    chk("R11 older leaves first", iss_opcode, 6'h10);
    chk("R2 accept in leave cycle", in_ready, 1);
    next();
    in_valid = 1'b0;
    @(negedge clk);
    chk("R11 younger follows", iss_valid, 1);
    chk("R11 younger opcode", iss_opcode, 6'h11);
    next();
    wbw(4, 16'h0404);
    wbw(6, 16'h0606);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_opcode = '0; in_fu = '0; in_dst = '0;
    in_src1 = '0; in_src2 = '0; fu_free = 2'b11; wb_valid = 1'b0; wb_reg = '0; wb_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_raw();
    t_waw();
    t_fu();
    t_war();
    t_r0();
    t_collide();
    t_order();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule